// File: doc/BRIEF.md
# Radix-8 Booth Digit Recoder

This block sits at the left edge of a row of multiply-accumulate processing elements. It takes one signed multiplier operand and rewrites it as a set of signed radix-8 digits, each in the range -4 to +4. Each digit leaves the block as five select lines: a negate flag and four magnitude lines for one, two, three and four times the multiplicand. The whole operand is recoded in parallel and then registered. The processing elements in the row can then pick a partial product directly, and none of them needs its own recoding logic.

The operand is treated as two's complement and sign-extended by two bits, so that the top window is complete. Each digit looks at three adjacent operand bits and at the top bit of the window below it. A zero is implied below the least significant bit. A window of three ones above a one still raises the negate flag, but none of its magnitude lines. Downstream logic must treat that as a zero partial product. The five lines are kept as separate wires and are not packed into a denser code.

Top module: `r8_digit_recoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `out_valid` = 0 and every select line = 0.
- R2: `out_valid` at each edge equals the `in_valid` sampled at that edge, so it lags `in_valid` by exactly one cycle.
- R3: The select lines load only at an edge where `in_valid` is 1. At any other edge they keep their value, whatever `in_op` does.
- R4: For every digit, at most one of `out_one`, `out_two`, `out_three`, `out_four` is high.
- R5: Let digit i have magnitude m (1 to 4 from the high magnitude line, or 0 when none is high). Its value is -m when `out_neg[i]` is 1 and +m otherwise. The sum over i of (digit value · 8^i) equals the signed value of the loaded `in_op`, for every 16-bit operand including -32768 and 32767.
- R6: A window whose three bits and whose borrow bit are all equal gives magnitude zero. With all ones, `out_neg` is high and no magnitude line is high. Loading -1 gives `out_neg` = 6'h3F, `out_one` = 6'h01 and the other lines 0. Loading 0 gives all lines 0.
- R7: There are ceil((16+1)/3) = 6 digits. Because of sign extension, the top digit (index 5) never raises `out_two`, `out_three` or `out_four`.
- R8: `out_neg[i]` equals bit 3i+2 of the loaded operand for digits 0 to 4, and the sign bit 15 for digit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand on `in_op` is to be loaded this cycle |
| in_op | input | 16 | Signed multiplier operand |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_one | output | 6 | Per-digit magnitude-one select |
| out_two | output | 6 | Per-digit magnitude-two select |
| out_three | output | 6 | Per-digit magnitude-three select |
| out_four | output | 6 | Per-digit magnitude-four select |
| out_neg | output | 6 | Per-digit negate flag |

## Verification
Every result of this block is due one clock after its operand. The select lines and `out_valid` both come from the single output register, so an operand driven before edge k is visible right after edge k. The bench drives on the falling edge and checks the previous operand's digits on the next falling edge, before it drives the next operand, so each comparison lines up with exactly one register stage. The hold behaviour and the valid drop are checked one and two cycles after `in_valid` is lowered. Reset clearing is checked on the falling edge after a reset edge.

// File: rtl/r8_pkg.sv
// Package: shared types and sizing helpers for the radix-8 recoder.
// Assumes: digit count is ceil((W+1)/3) for a W-bit signed operand.
package r8_pkg;

    // One digit's select code, kept in five separate lines.
    typedef struct packed {
        logic neg;
        logic four;
        logic three;
        logic two;
        logic one;
    } r8_sel_t;

    // Number of radix-8 digits needed for a w-bit two's complement operand.
    function automatic int r8_digits(input int w);
        return (w + 3) / 3;
    endfunction

endpackage

// File: rtl/r8_sign_ext.sv
// Module: r8_sign_ext
// Widens a signed operand to a multiple of three bits and appends the
// implicit zero borrow bit below bit 0. Output bit k+1 holds operand bit k.
// Assumes: EXT_W >= IN_W.
module r8_sign_ext #(
    parameter int IN_W  = 16,
    parameter int EXT_W = 18
) (
    input  logic [IN_W-1:0] op,
    output logic [EXT_W:0]  ext
);
    localparam int PAD_W = EXT_W - IN_W;

    // Replicate the sign into the pad bits and add the zero borrow.
    always_comb begin
        ext = {{PAD_W{op[IN_W-1]}}, op, 1'b0};
    end
endmodule

// File: rtl/r8_digit_cell.sv
// Module: r8_digit_cell
// Turns one 4-bit window (three operand bits plus the borrow below them)
// into a five-line select code.
// win[3] = top bit, win[2], win[1] = lower two bits, win[0] = borrow.
// Assumes: the caller supplies overlapping windows. The all-ones window
// gives neg=1 with no magnitude line high.
module r8_digit_cell
    import r8_pkg::*;
(
    input  logic [3:0] win,
    output r8_sel_t    sel
);
    logic hi_x, lo_x, mid_x;

    // Pairwise differences between neighbouring window bits.
    always_comb begin
        hi_x  = win[3] ^ win[2];
        mid_x = win[2] ^ win[1];
        lo_x  = win[1] ^ win[0];
    end

    // Magnitude and sign decode.
    always_comb begin
        sel.one   = ~hi_x & lo_x;
        sel.two   = mid_x & ~lo_x;
        sel.three = hi_x & lo_x;
        sel.four  = hi_x & ~mid_x & ~lo_x;
        sel.neg   = win[3];
    end
endmodule

// File: rtl/r8_sel_reg.sv
// Module: r8_sel_reg
// Output register for all digit codes plus a valid flag. Codes load only
// when in_valid is high. Synchronous active-low reset clears everything.
module r8_sel_reg
    import r8_pkg::*;
#(
    parameter int DIGITS = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  r8_sel_t [DIGITS-1:0]   sel_d,
    output logic                   out_valid,
    output r8_sel_t [DIGITS-1:0]   sel_q
);
    // Valid flag follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Select codes load on a valid strobe and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= '0;
        else if (in_valid) sel_q <= sel_d;
    end
endmodule

// File: rtl/r8_digit_recoder.sv
// Module: r8_digit_recoder (top)
// Radix-8 recoder for one systolic array row. It sign-extends the operand,
// recodes every digit in parallel and registers the codes. It outputs one
// bit per digit on each of the five select buses.
// Assumes: OP_W >= 3. Downstream logic treats neg with no magnitude as zero.
module r8_digit_recoder
    import r8_pkg::*;
#(
    parameter int OP_W = 16,
    parameter int DIGITS = r8_digits(OP_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    output logic              out_valid,
    output logic [DIGITS-1:0] out_one,
    output logic [DIGITS-1:0] out_two,
    output logic [DIGITS-1:0] out_three,
    output logic [DIGITS-1:0] out_four,
    output logic [DIGITS-1:0] out_neg
);
    localparam int EXT_W = 3 * DIGITS;

    logic [EXT_W:0]        ext;
    r8_sel_t [DIGITS-1:0]  sel_d;
    r8_sel_t [DIGITS-1:0]  sel_q;

    r8_sign_ext #(.IN_W(OP_W), .EXT_W(EXT_W)) u_ext (
        .op  (in_op),
        .ext (ext)
    );

    // One recoding cell per digit, each on its own overlapping window.
    for (genvar g = 0; g < DIGITS; g++) begin : g_cell
        r8_digit_cell u_cell (
            .win (ext[3*g+3 : 3*g]),
            .sel (sel_d[g])
        );
    end

    r8_sel_reg #(.DIGITS(DIGITS)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sel_d     (sel_d),
        .out_valid (out_valid),
        .sel_q     (sel_q)
    );

    // Split the registered codes into per-line buses.
    always_comb begin
        for (int k = 0; k < DIGITS; k++) begin
            out_one[k]   = sel_q[k].one;
            out_two[k]   = sel_q[k].two;
            out_three[k] = sel_q[k].three;
            out_four[k]  = sel_q[k].four;
            out_neg[k]   = sel_q[k].neg;
        end
    end
endmodule

// File: rtl/r8_digit_recoder_chk.sv
// Module: r8_digit_recoder_chk
// Checker attached to the recoder's ports. It relates the outputs to the
// operand and the strobe one cycle earlier.
module r8_digit_recoder_chk #(
    parameter int OP_W = 16,
    parameter int DIGITS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic              out_valid,
    input logic [DIGITS-1:0] out_one,
    input logic [DIGITS-1:0] out_two,
    input logic [DIGITS-1:0] out_three,
    input logic [DIGITS-1:0] out_four,
    input logic [DIGITS-1:0] out_neg
);
    logic seen_edge = 1'b0;

    // Marks that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // Value the digit codes stand for, rebuilt from the output lines.
    function automatic int rebuild(input logic [DIGITS-1:0] o1, o2, o3, o4, ng);
        int acc = 0;
        for (int i = 0; i < DIGITS; i++) begin
            int m;
            m = o4[i] ? 4 : o3[i] ? 3 : o2[i] ? 2 : o1[i] ? 1 : 0;
            acc += (ng[i] ? -m : m) * (1 << (3 * i));
        end
        return acc;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (seen_edge && !$past(rst_n)) |-> (!out_valid && out_one == '0 && out_two == '0
            && out_three == '0 && out_four == '0 && out_neg == '0)); // R1

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n)) |-> (out_valid == $past(in_valid))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n) && !$past(in_valid)) |-> ($stable(out_one) && $stable(out_two)
            && $stable(out_three) && $stable(out_four) && $stable(out_neg))); // R3

    AST_SUM_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n) && $past(in_valid)) |->
            (rebuild(out_one, out_two, out_three, out_four, out_neg)
                == int'($signed($past(in_op))))); // R5

    AST_TOP_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_two[DIGITS-1] || out_three[DIGITS-1] || out_four[DIGITS-1])); // R7

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        localparam int NB = (3 * g + 2 < OP_W) ? 3 * g + 2 : OP_W - 1;

        AST_MAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({out_one[g], out_two[g], out_three[g], out_four[g]})); // R4

        AST_NEG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_edge && $past(rst_n) && $past(in_valid)) |->
                (out_neg[g] == $past(in_op[NB]))); // R8
    end
endmodule

bind r8_digit_recoder r8_digit_recoder_chk #(.OP_W(OP_W), .DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_one   (out_one),
    .out_two   (out_two),
    .out_three (out_three),
    .out_four  (out_four),
    .out_neg   (out_neg)
);

// File: tb/test_r8_digit_recoder.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of all 16-bit operands with arithmetic
// reconstruction, plus directed hold, reset and zero-window cases.
module test_r8_digit_recoder;
    localparam int W = 16;
    localparam int D = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_op = '0;
    logic         out_valid;
    logic [D-1:0] out_one, out_two, out_three, out_four, out_neg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    r8_digit_recoder i_r8_digit_recoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .out_valid (out_valid),
        .out_one   (out_one),
        .out_two   (out_two),
        .out_three (out_three),
        .out_four  (out_four),
        .out_neg   (out_neg)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Full per-vector check of the outputs for operand v.
    task automatic check_vec(input logic [W-1:0] v);
        int sum = 0;
        int multi = 0;
        for (int i = 0; i < D; i++) begin
            int m;
            int nb;
            int cnt;
            cnt = out_one[i] + out_two[i] + out_three[i] + out_four[i];
            if (cnt > 1) multi++;
            m = out_four[i] ? 4 : out_three[i] ? 3 : out_two[i] ? 2 : out_one[i] ? 1 : 0;
            sum += (out_neg[i] ? -m : m) * (1 << (3 * i));
            nb = (3 * i + 2 < W) ? 3 * i + 2 : W - 1;
            check(out_neg[i] == v[nb], "R8 neg bit", int'(out_neg[i]), int'(v[nb]));
        end
        check(multi == 0, "R4 one-hot magnitude", multi, 0);
        check(sum == int'($signed(v)), "R5 reconstruction", sum, int'($signed(v)));
        check({out_two[D-1], out_three[D-1], out_four[D-1]} == 3'b000, "R7 top digit",
              int'({out_two[D-1], out_three[D-1], out_four[D-1]}), 0);
        check(out_valid == 1'b1, "R2 valid lag", int'(out_valid), 1);
    endtask

    task automatic check_clear();
        check(out_valid == 1'b0, "R1 valid cleared", int'(out_valid), 0);
        check({out_one, out_two, out_three, out_four, out_neg} == '0, "R1 lines cleared",
              int'({out_one, out_two, out_three, out_four, out_neg}), 0);
    endtask

    // Load one operand and check it on the following falling edge.
    task automatic load_and_check(input logic [W-1:0] v);
        @(negedge clk);
        in_op = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(v);
    endtask

    initial begin
        logic [5*D-1:0] snap;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_clear();
        rst_n = 1'b1;

        // R5/R4/R7/R8/R2: every operand, one per cycle, checked one cycle later
        for (int v = 0; v < (1 << W); v++) begin
            @(negedge clk);
            if (v > 0) check_vec(W'(v - 1));
            in_op = W'(v);
            in_valid = 1'b1;
        end
        @(negedge clk);
        check_vec({W{1'b1}});

        // R3: strobe low, operand changes, lines must hold; R2 valid drops
        snap = {out_one, out_two, out_three, out_four, out_neg};
        in_valid = 1'b0;
        in_op = 16'h1234;
        @(negedge clk);
        check({out_one, out_two, out_three, out_four, out_neg} == snap, "R3 hold",
              int'({out_one, out_two, out_three, out_four, out_neg}), int'(snap));
        check(out_valid == 1'b0, "R2 valid drop", int'(out_valid), 0);
        in_op = 16'h8001;
        @(negedge clk);
        check({out_one, out_two, out_three, out_four, out_neg} == snap, "R3 hold second",
              int'({out_one, out_two, out_three, out_four, out_neg}), int'(snap));

        // R5 extremes
        load_and_check(16'h8000);
        load_and_check(16'h7FFF);

        // R6: all-ones windows give negate with zero magnitude
        load_and_check(16'hFFFF);
        check(out_neg == 6'h3F, "R6 neg for -1", int'(out_neg), 'h3F);
        check(out_one == 6'h01, "R6 one for -1", int'(out_one), 1);
        check({out_two, out_three, out_four} == '0, "R6 no big magnitude for -1",
              int'({out_two, out_three, out_four}), 0);
        // R6: all-zero windows
        load_and_check(16'h0000);
        check({out_one, out_two, out_three, out_four, out_neg} == '0, "R6 zero operand",
              int'({out_one, out_two, out_three, out_four, out_neg}), 0);

        // R1: reset again after non-zero state
        load_and_check(16'h5A5A);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_clear();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule